// File: doc/BRIEF.md
# Unaligned Load Merger for a 32-bit Read Bus

This block turns a load request of any byte alignment into the aligned read transfers that a 32-bit AHB-Lite master may legally issue, then assembles the bytes that come back into a right-aligned result. A halfword that sits on an even byte uses one 16-bit transfer. A halfword on byte 1 uses one full-word read. A load whose bytes spill into the following word is served by two full-word reads, first at the containing word and then at the word above it.

The bus side runs strictly one transfer at a time. The second address phase is issued only after the first data phase has ended with the ready signal high. The bytes are merged little-endian. Byte `i` of the result is the memory byte at request address plus `i`, and a halfword result is zero-filled above bit 15. An error response on either read raises the error flag in place of the data. A new request is taken only while the block is idle.

Top module: `ld_merge_top`

## Requirements
- R1: A halfword request (`reqWord`=0) whose address ends in binary 00 or 10 makes exactly one transfer, at the request address itself, with `hSize`=3'b001 (16 bits).
- R2: A halfword request whose address ends in 01 makes exactly one transfer, at the address with its two low bits cleared, with `hSize`=3'b010 (32 bits).
- R3: A halfword request ending in 11, or a word request (`reqWord`=1) ending in 01, 10 or 11, makes two 32-bit transfers. The first is at the address with its two low bits cleared and the second is at that address plus 4, wrapping at the top of the address space.
- R4: A word request whose address ends in 00 makes exactly one 32-bit transfer at the request address.
- R5: Every transfer has `hBurst`=3'b000 (single) and `hWrite`=0. `hTrans` only ever shows 2'b00 (idle) or 2'b10 (non-sequential). `hSize` is never above 3'b010, and the address is aligned to `hSize`, so no transfer leaves its 4-byte word.
- R6: An address phase holds `hAddr` and `hTrans` while `hReady` is low. No new address phase overlaps a data phase that has not yet completed with `hReady` high.
- R7: On a good response, byte `i` of `rspData` (bits 8i+7..8i) equals the memory byte at request address + `i`, for `i` below 2 (halfword) or 4 (word).
- R8: For a halfword request, `rspData[31:16]` is zero.
- R9: If either read returns `hResp`=1, `rspError` is 1 and `rspData` is 0 with `rspValid`. An error on the first read of a two-read request suppresses the second transfer.
- R10: During reset `hTrans` is idle and `rspValid` is 0. After a request, `rspValid` pulses high for exactly one cycle, in the cycle after the last data phase completes.
- R11: `reqValid` is ignored while a request is in progress: it starts no transfer and does not change the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Load request strobe, taken when idle |
| reqAddr | input | ADDR_W | Byte address of the load |
| reqWord | input | 1 | 1 = 32-bit load, 0 = 16-bit load |
| rspValid | output | 1 | One-cycle result strobe |
| rspData | output | 32 | Right-aligned, zero-filled result |
| rspError | output | 1 | A read returned an error |
| hAddr | output | ADDR_W | Bus address |
| hTrans | output | 2 | Bus transfer type (idle or non-sequential) |
| hSize | output | 3 | Bus transfer size |
| hBurst | output | 3 | Bus burst type, always single |
| hWrite | output | 1 | Bus direction, always read |
| hRdata | input | 32 | Bus read data |
| hReady | input | 1 | Bus ready |
| hResp | input | 1 | Bus error response |

## Verification
A wrong byte-offset or request-size register shows up within one address phase, as the wrong transfer address, size or count in the bus log. It also appears at the response as rotated bytes or non-zero upper bits. A sequencer state that skips or repeats a phase changes the number of transfers or overlaps a data phase. It also moves the `rspValid` pulse away from the cycle after the final completed data phase, so it is seen by the end of the same request. A stale error bit shows up on the next response as a zeroed result with the error flag set.

// File: rtl/ld_merge_pkg.sv
package ld_merge_pkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = BUS_BYTES * 8;
  localparam int OFF_W     = $clog2(BUS_BYTES);

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [2:0] SIZE_HALF    = 3'b001;
  localparam logic [2:0] SIZE_WORD    = 3'b010;
  localparam logic [2:0] BURST_SINGLE = 3'b000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR1, ST_DATA1, ST_ADDR2, ST_DATA2, ST_DONE
  } mergeState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic latchReq;   // capture the new request
    logic capFirst;   // first data phase completes
    logic capSecond;  // second data phase completes
    logic useNext;    // drive the following word address
  } mergeCtl_t;
endpackage

// File: rtl/ld_merge_ctrl.sv
module ld_merge_ctrl
  import ld_merge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        needTwo,
  input  logic        hReady,
  input  logic        hResp,
  output mergeCtl_t   ctl,
  output logic [1:0]  hTrans,
  output logic        rspValid
);
  mergeState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    hTrans    = TRANS_IDLE;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          nextState    = ST_ADDR1;
        end
      end
      ST_ADDR1: begin
        hTrans = TRANS_NONSEQ;
        if (hReady) nextState = ST_DATA1;
      end
      ST_DATA1: begin
        if (hReady) begin
          ctl.capFirst = 1'b1;
          nextState    = (needTwo && !hResp) ? ST_ADDR2 : ST_DONE;
        end
      end
      ST_ADDR2: begin
        ctl.useNext = 1'b1;
        hTrans      = TRANS_NONSEQ;
        if (hReady) nextState = ST_DATA2;
      end
      ST_DATA2: begin
        ctl.useNext = 1'b1;
        if (hReady) begin
          ctl.capSecond = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign rspValid = (state == ST_DONE);
endmodule

// File: rtl/ld_merge_dp.sv
module ld_merge_dp
  import ld_merge_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mergeCtl_t         ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWord,
  input  logic [BUS_W-1:0]  hRdata,
  input  logic              hResp,
  input  logic              rspValid,
  output logic [ADDR_W-1:0] hAddr,
  output logic [2:0]        hSize,
  output logic              needTwo,
  output logic [BUS_W-1:0]  rspData,
  output logic              rspError
);
  localparam int JOIN_BYTES = 2 * BUS_BYTES;
  localparam int IDX_W      = $clog2(JOIN_BYTES);

  logic [ADDR_W-1:0] addrQ;
  logic              wordQ;
  logic [BUS_W-1:0]  firstQ, secondQ;
  logic              errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wordQ   <= 1'b0;
      firstQ  <= '0;
      secondQ <= '0;
      errQ    <= 1'b0;
    end else begin
      if (ctl.latchReq) begin
        addrQ <= reqAddr;
        wordQ <= reqWord;
        errQ  <= 1'b0;
      end
      if (ctl.capFirst) begin
        firstQ <= hRdata;
        if (hResp) errQ <= 1'b1;
      end
      if (ctl.capSecond) begin
        secondQ <= hRdata;
        if (hResp) errQ <= 1'b1;
      end
    end
  end

  logic [OFF_W-1:0]  offset;
  logic [ADDR_W-1:0] alignedAddr, nextAddr;
  logic              narrow;

  assign offset      = addrQ[OFF_W-1:0];
  assign alignedAddr = {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign nextAddr    = alignedAddr + ADDR_W'(BUS_BYTES);
  assign narrow      = !wordQ && !offset[0];
  assign needTwo     = wordQ ? (offset != '0) : (offset == OFF_W'(BUS_BYTES - 1));
  assign hAddr       = ctl.useNext ? nextAddr : (narrow ? addrQ : alignedAddr);
  assign hSize       = narrow ? SIZE_HALF : SIZE_WORD;

  // byte lane selection from the two fetched words, little-endian
  logic [JOIN_BYTES-1:0][7:0] joined;
  logic [BUS_BYTES-1:0][7:0]  merged;
  assign joined = {secondQ, firstQ};

  for (genvar k = 0; k < BUS_BYTES; k++) begin : gLane
    logic [IDX_W-1:0] srcIdx;
    assign srcIdx = IDX_W'(offset) + IDX_W'(k);
    if (k < BUS_BYTES / 2) begin : gLow
      assign merged[k] = joined[srcIdx];
    end else begin : gHigh
      assign merged[k] = wordQ ? joined[srcIdx] : 8'h00;
    end
  end

  assign rspData  = (rspValid && !errQ) ? merged : '0;
  assign rspError = rspValid && errQ;
endmodule

// File: rtl/ld_merge_top.sv
module ld_merge_top
  import ld_merge_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWord,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              rspError,
  output logic [ADDR_W-1:0] hAddr,
  output logic [1:0]        hTrans,
  output logic [2:0]        hSize,
  output logic [2:0]        hBurst,
  output logic              hWrite,
  input  logic [31:0]       hRdata,
  input  logic              hReady,
  input  logic              hResp
);
  mergeCtl_t ctl;
  logic      needTwo;

  ld_merge_ctrl ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .needTwo  (needTwo),
    .hReady   (hReady),
    .hResp    (hResp),
    .ctl      (ctl),
    .hTrans   (hTrans),
    .rspValid (rspValid)
  );

  ld_merge_dp #(.ADDR_W(ADDR_W)) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWord  (reqWord),
    .hRdata   (hRdata),
    .hResp    (hResp),
    .rspValid (rspValid),
    .hAddr    (hAddr),
    .hSize    (hSize),
    .needTwo  (needTwo),
    .rspData  (rspData),
    .rspError (rspError)
  );

  assign hBurst = BURST_SINGLE;
  assign hWrite = 1'b0;
endmodule

// File: rtl/ld_merge_chk.sv
module ld_merge_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hAddr,
  input logic [1:0]        hTrans,
  input logic [2:0]        hSize,
  input logic [2:0]        hBurst,
  input logic              hWrite,
  input logic              hReady,
  input logic              rspValid,
  input logic [31:0]       rspData,
  input logic              rspError
);
  assert_trans_kind_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans == 2'b00) || (hTrans == 2'b10));

  assert_single_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans == 2'b10) |-> (hBurst == 3'b000 && !hWrite && hSize <= 3'b010));

  assert_word_align_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans == 2'b10 && hSize == 3'b010) |-> (hAddr[1:0] == 2'b00));

  assert_half_align_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans == 2'b10 && hSize == 3'b001) |-> !hAddr[0]);

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans == 2'b10 && !hReady) |=> (hTrans == 2'b10 && $stable(hAddr)));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans == 2'b10 && hReady) |=> (hTrans == 2'b00));

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_rsp_after_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> ($past(hReady) && $past(hTrans) == 2'b00));

  assert_err_blank_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> (rspData == 32'h0));

  assert_quiet_out_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspError && rspData == 32'h0));
endmodule

bind ld_merge_top ld_merge_chk #(.ADDR_W(ADDR_W)) chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .hAddr    (hAddr),
  .hTrans   (hTrans),
  .hSize    (hSize),
  .hBurst   (hBurst),
  .hWrite   (hWrite),
  .hReady   (hReady),
  .rspValid (rspValid),
  .rspData  (rspData),
  .rspError (rspError)
);

// File: tb/ld_merge_top_test.sv
module ld_merge_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              rstN;
  logic              reqValid;
  logic [ADDR_W-1:0] reqAddr;
  logic              reqWord;
  logic              rspValid;
  logic [31:0]       rspData;
  logic              rspError;
  logic [ADDR_W-1:0] hAddr;
  logic [1:0]        hTrans;
  logic [2:0]        hSize;
  logic [2:0]        hBurst;
  logic              hWrite;
  logic [31:0]       hRdata;
  logic              hReady;
  logic              hResp;

  ld_merge_top #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWord(reqWord), .rspValid(rspValid), .rspData(rspData),
    .rspError(rspError), .hAddr(hAddr), .hTrans(hTrans), .hSize(hSize),
    .hBurst(hBurst), .hWrite(hWrite), .hRdata(hRdata), .hReady(hReady),
    .hResp(hResp)
  );

  int checks   = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[31:24] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] b = {a[31:2], 2'b00};
    return {memByte(b + 3), memByte(b + 2), memByte(b + 1), memByte(b)};
  endfunction

  // bus slave model with random wait states and two-cycle error response
  bit               errEn;
  logic [29:0]      errWord;
  int               xferCount;
  int               overlapCount;
  logic [31:0]      xAddr [4];
  logic [2:0]       xSize [4];
  logic [2:0]       xBurst[4];
  logic             xWrite[4];
  bit               pend;
  bit               pErr;
  bit               errHalf;
  int               waitLeft;
  logic [31:0]      pAddr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hReady <= 1'b1;
      hResp  <= 1'b0;
      hRdata <= '0;
      pend = 1'b0;
    end else begin
      if (pend && hTrans == 2'b10) overlapCount++;
      if (pend && hReady) pend = 1'b0;
      if (hReady && hTrans == 2'b10) begin
        pend     = 1'b1;
        pAddr    = hAddr;
        waitLeft = int'($urandom % 3);
        pErr     = errEn && (hAddr[31:2] == errWord);
        errHalf  = 1'b0;
        if (xferCount < 4) begin
          xAddr[xferCount]  = hAddr;
          xSize[xferCount]  = hSize;
          xBurst[xferCount] = hBurst;
          xWrite[xferCount] = hWrite;
        end
        xferCount++;
      end
      if (pend) begin
        if (waitLeft > 0) begin
          hReady <= 1'b0; hResp <= 1'b0; waitLeft--;
        end else if (pErr && !errHalf) begin
          hReady <= 1'b0; hResp <= 1'b1; errHalf = 1'b1;
        end else begin
          hReady <= 1'b1; hResp <= pErr; hRdata <= memWord(pAddr);
        end
      end else begin
        hReady <= 1'b1;
        hResp  <= 1'b0;
      end
    end
  end

  task automatic doLoad(input logic [31:0] a, input bit w, input bit eEn,
                        input logic [29:0] eW, input bit poke);
    logic [1:0]  off      = a[1:0];
    bit          twoReads = w ? (off != 2'd0) : (off == 2'd3);
    bit          narrow   = !w && !off[0];
    logic [31:0] aligned  = {a[31:2], 2'b00};
    logic [31:0] second   = aligned + 32'd4;
    logic [31:0] firstA   = narrow ? a : aligned;
    bit          err1     = eEn && (aligned[31:2] == eW);
    bit          err2     = eEn && twoReads && !err1 && (second[31:2] == eW);
    bit          expErr   = err1 || err2;
    int          expCount = (twoReads && !err1) ? 2 : 1;
    logic [31:0] expData  = '0;
    string       tag;
    int          t        = 0;
    int          countAtRsp;
    if (!w && off[0] == 1'b0) tag = "R1";
    else if (!w && off == 2'd1) tag = "R2";
    else if (twoReads) tag = "R3";
    else tag = "R4";
    if (!expErr)
      for (int i = 0; i < (w ? 4 : 2); i++) expData[8*i +: 8] = memByte(a + i);

    errEn = eEn; errWord = eW; xferCount = 0; overlapCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWord = w;
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin
      reqValid = 1'b1; reqAddr = a ^ 32'h0000_0101; reqWord = ~w;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (!rspValid && t < 60) begin
      @(negedge clk);
      t++;
    end
    countAtRsp = xferCount;
    check(rspValid, "R10", "rspValid seen", 64'(rspValid), 64'd1);
    check(rspError == expErr, "R9", "rspError", 64'(rspError), 64'(expErr));
    check(rspData == expData, expErr ? "R9" : "R7", "rspData", 64'(rspData), 64'(expData));
    if (!w) check(rspData[31:16] == 16'h0, "R8", "upper half", 64'(rspData[31:16]), 64'd0);
    check(countAtRsp == expCount, err1 && twoReads ? "R9" : tag, "transfer count",
          64'(countAtRsp), 64'(expCount));
    check(xAddr[0] == firstA, tag, "first address", 64'(xAddr[0]), 64'(firstA));
    check(xSize[0] == (narrow ? 3'b001 : 3'b010), tag, "first size",
          64'(xSize[0]), 64'(narrow ? 3'b001 : 3'b010));
    check(xBurst[0] == 3'b000 && !xWrite[0], "R5", "burst/write", 64'({xBurst[0], xWrite[0]}), 64'd0);
    if (expCount == 2) begin
      check(xAddr[1] == second, "R3", "second address", 64'(xAddr[1]), 64'(second));
      check(xSize[1] == 3'b010, "R3", "second size", 64'(xSize[1]), 64'd2);
    end
    check(overlapCount == 0, "R6", "overlapping address phase", 64'(overlapCount), 64'd0);
    @(negedge clk);
    check(!rspValid, "R10", "pulse width", 64'(rspValid), 64'd0);
    @(negedge clk);
    @(negedge clk);
    check(xferCount == countAtRsp, "R11", "no stray transfer", 64'(xferCount), 64'(countAtRsp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seedInit;
    seedInit = int'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqWord = 1'b0;
    errEn = 1'b0; errWord = '0; xferCount = 0; overlapCount = 0;
    repeat (3) @(negedge clk);
    check(hTrans == 2'b00, "R10", "reset hTrans", 64'(hTrans), 64'd0);
    check(!rspValid, "R10", "reset rspValid", 64'(rspValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: every offset and size
    for (int o = 0; o < 4; o++) begin
      doLoad(32'h0000_1230 + 32'(o), 1'b0, 1'b0, '0, 1'b0);
      doLoad(32'h0000_4560 + 32'(o), 1'b1, 1'b0, '0, 1'b1);
    end
    // error on first of two, on second of two, on a single read
    doLoad(32'h0000_2003, 1'b1, 1'b1, 30'(32'h2000 >> 2), 1'b0);
    doLoad(32'h0000_2003, 1'b1, 1'b1, 30'(32'h2004 >> 2), 1'b0);
    doLoad(32'h0000_3002, 1'b0, 1'b1, 30'(32'h3000 >> 2), 1'b0);
    // good load right after an error clears the flag
    doLoad(32'h0000_3001, 1'b0, 1'b0, '0, 1'b0);
    // wrap at the top of the address space
    doLoad(32'hFFFF_FFFE, 1'b1, 1'b0, '0, 1'b0);
    doLoad(32'hFFFF_FFFF, 1'b0, 1'b0, '0, 1'b1);

    for (int n = 0; n < 200; n++) begin
      logic [31:0] a  = $urandom;
      bit          w  = $urandom % 2;
      bit          e  = ($urandom % 8) == 0;
      logic [29:0] ew = a[31:2] + 30'($urandom % 2);
      doLoad(a, w, e, ew, ($urandom % 2) == 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule